// File: doc/BRIEF.md
# Converter Serial Readout Controller

This block is the device side of a three-wire serial readout for a converter that produces a 16-bit result. It moves through three states. In CONVERT a parameterized cycle counter models the conversion time. When the counter expires, the block captures a result word from a test input and falls into a low-power SLEEP state. In DATA OUTPUT it shifts the captured word out on the serial data line, most significant bit first.

The host drives an active-low chip select and a serial clock. The block samples both through synchronizers on a fast system clock and works from edges it detects on the synchronized copies. While chip select is low, the data line doubles as a busy flag: it reads high during a conversion and low once a result is waiting. Two host clocking styles are supported:

- **Clock idling high:** the status can be read before any data moves.
- **Clock idling low:** the first data bit appears as soon as chip select falls.

A new conversion starts in any of three ways:

- chip select rises after a full readout;
- one extra clock falling edge arrives after all sixteen bits;
- chip select rises in the middle of a readout, which abandons it.

Top module: `conv_serial_port`

## Requirements
- R1: Synchronous active-high reset puts the block in CONVERT with its timer cleared and both outputs low. A result is available only after a full conversion time from the release of reset.
- R2: `sdo_oe` is 1 exactly when chip select is low, so the data line is released (high impedance) whenever `cs_n` is high, in every state.
- R3: In CONVERT with `cs_n` low, `sdo` is 1. Serial clock edges have no effect in this state.
- R4: CONVERT lasts exactly CONV_CYCLES system clock cycles. The block then enters SLEEP on its own, and the result is the value of `conv_word` in the final cycle of the conversion. Later changes of `conv_word` do not alter the word read out.
- R5: In SLEEP with `cs_n` low, `sdo` is 0. This also holds when `cs_n` was already low when the conversion ended.
- R6: If `cs_n` falls in SLEEP while `sclk` is high, `sdo` stays 0 until the first `sclk` falling edge. That edge presents bit 15. Each later falling edge presents the next lower bit, down to bit 0. A falling `sclk` edge in SLEEP with `cs_n` already low likewise presents bit 15.
- R7: If `cs_n` falls in SLEEP while `sclk` is low, bit 15 appears at once. Each `sclk` falling edge presents the next lower bit.
- R8: After sixteen `sclk` rising edges have read the word, a rising edge of `cs_n` starts a new conversion.
- R9: After sixteen `sclk` rising edges have read the word, an `sclk` falling edge with `cs_n` still low starts a new conversion.
- R10: A rising edge of `cs_n` at any point of DATA OUTPUT before the word is complete abandons the readout and starts a new conversion.
- R11: With the default of two synchronizer stages, a change on `cs_n` or `sclk` reaches the outputs at the fourth rising system clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select from the host, active low, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| conv_word | input | DATA_W | Test value captured as the conversion result |
| sdo | output | 1 | Serial data or status bit, registered |
| sdo_oe | output | 1 | Output enable for the data line, registered |

## Verification
Every pin change passes through two synchronizer flops and one edge-detect register before the state, the shift register and the timer update. One more edge registers the outputs, so `sdo` and `sdo_oe` settle at the fourth system clock edge after a pin change. The bench checks that boundary directly: `sdo_oe` is still low after three edges and high after the fourth. Every other stimulus is applied on a falling clock edge and held for six system cycles before the outputs are sampled on a falling edge, which keeps each check clear of the four-cycle latency. Conversion timing is checked against a window anchored to the restart stimulus: halfway through the conversion time the line must read busy, and thirty cycles past its end it must read idle or show data.

// File: rtl/conv_pkg.sv
package conv_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_SHIFT = 2'd2
  } conv_state_e;
endpackage

// File: rtl/conv_sync_edge.sv
// Multi-stage synchronizer followed by an edge-detect register.
// level is the delayed copy, so level and the edge pulses change together.
module conv_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RST_VAL;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= chain[STAGES-1];
  end

  assign level = prev;
  assign rise  = chain[STAGES-1] & ~prev;
  assign fall  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/conv_timer.sv
// Conversion time model: counts while run is high and captures the word on the last cycle.
module conv_timer #(
  parameter int CONV_CYCLES = 2000,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [DATA_W-1:0] sample,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  localparam int            CW   = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (done)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       result <= '0;
    else if (done) result <= sample;
  end
endmodule

// File: rtl/conv_shifter.sv
// Parallel-load shift register, MSB presented first.
module conv_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  output logic              msb
);
  logic [DATA_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= din;
    else if (shift) sr <= {sr[DATA_W-2:0], 1'b0};
  end

  assign msb = sr[DATA_W-1];
endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port
  import conv_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] conv_word,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int            RW      = $clog2(DATA_W + 1);
  localparam logic [RW-1:0] RD_FULL = RW'(DATA_W);

  logic cs_lvl, cs_rise, cs_fall;
  logic sck_lvl, sck_rise, sck_fall;

  conv_state_e       state_q, state_d;
  logic              hold_q, hold_d;     // status shown until the first falling clock edge
  logic [RW-1:0]     rd_q, rd_d;         // rising edges seen during readout
  logic              load_sr, shift_sr;
  logic              conv_done, sr_msb;
  logic [DATA_W-1:0] result;

  conv_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .din(cs_n),
    .level(cs_lvl), .rise(cs_rise), .fall(cs_fall)
  );

  conv_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst(rst), .din(sclk),
    .level(sck_lvl), .rise(sck_rise), .fall(sck_fall)
  );

  conv_timer #(.CONV_CYCLES(CONV_CYCLES), .DATA_W(DATA_W)) u_timer (
    .clk(clk), .rst(rst), .run(state_q == ST_CONV),
    .sample(conv_word), .done(conv_done), .result(result)
  );

  conv_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(load_sr), .shift(shift_sr),
    .din(result), .msb(sr_msb)
  );

  always_comb begin
    state_d  = state_q;
    hold_d   = hold_q;
    rd_d     = rd_q;
    load_sr  = 1'b0;
    shift_sr = 1'b0;
    case (state_q)
      ST_CONV: begin
        if (conv_done) state_d = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (cs_fall) begin
          state_d = ST_SHIFT;
          hold_d  = sck_lvl;
          rd_d    = '0;
          load_sr = 1'b1;
        end else if (!cs_lvl && sck_fall) begin
          state_d = ST_SHIFT;
          hold_d  = 1'b0;
          rd_d    = '0;
          load_sr = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (cs_rise) begin
          state_d = ST_CONV;
        end else begin
          if (sck_fall) begin
            if (rd_q == RD_FULL) state_d = ST_CONV;
            else if (hold_q)     hold_d = 1'b0;
            else                 shift_sr = 1'b1;
          end
          if (sck_rise && !hold_q && rd_q != RD_FULL) rd_d = rd_q + 1'b1;
        end
      end
      default: state_d = ST_CONV;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_CONV;
      hold_q  <= 1'b0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      rd_q    <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      sdo_oe <= !cs_lvl;
      case (state_q)
        ST_CONV:  sdo <= !cs_lvl;
        ST_SLEEP: sdo <= 1'b0;
        ST_SHIFT: sdo <= !cs_lvl && !hold_q && sr_msb;
        default:  sdo <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/conv_serial_port_chk.sv
module conv_serial_port_chk
  import conv_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 2000
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          cs_lvl,
  input logic                          cs_rise,
  input logic                          sck_fall,
  input conv_state_e                   state_q,
  input logic [$clog2(DATA_W+1)-1:0]   rd_q,
  input logic                          hold_q,
  input logic                          sdo,
  input logic                          sdo_oe
);
  localparam int RW = $clog2(DATA_W + 1);

  logic [31:0] conv_run;
  always_ff @(posedge clk) begin
    if (rst)                     conv_run <= '0;
    else if (state_q == ST_CONV) conv_run <= conv_run + 1'b1;
    else                         conv_run <= '0;
  end

  p_oe_off_r2: assert property (@(posedge clk) disable iff (rst) cs_lvl |=> !sdo_oe);
  p_oe_on_r2:  assert property (@(posedge clk) disable iff (rst) !cs_lvl |=> sdo_oe);

  p_busy_high_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV && !cs_lvl) |=> sdo);

  p_conv_len_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && $past(state_q) == ST_CONV) |-> conv_run == 32'(CONV_CYCLES));

  p_sleep_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && $past(state_q) != ST_SLEEP) |-> $past(state_q) == ST_CONV);

  p_sleep_low_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && !cs_lvl) |=> !sdo);

  p_status_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SHIFT && hold_q && !cs_lvl) |=> !sdo);

  p_restart_sck_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SHIFT && !cs_rise && sck_fall && rd_q == RW'(DATA_W)) |=> state_q == ST_CONV);

  p_abort_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SHIFT && cs_rise) |=> state_q == ST_CONV);
endmodule

bind conv_serial_port conv_serial_port_chk #(
  .DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .cs_lvl(cs_lvl), .cs_rise(cs_rise), .sck_fall(sck_fall),
  .state_q(state_q), .rd_q(rd_q), .hold_q(hold_q), .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/tb_conv_serial_port.sv
`timescale 1ns/1ps
module tb_conv_serial_port;
  localparam int DATA_W = 16;
  localparam int CONV   = 400;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cs_n = 1'b1;
  logic              sclk = 1'b1;
  logic [DATA_W-1:0] conv_word = '0;
  logic              sdo, sdo_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t0 = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  conv_serial_port #(.DATA_W(DATA_W), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
    .conv_word(conv_word), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  function automatic logic bit_at(logic [DATA_W-1:0] w, int i);
    return w[DATA_W-1-i];
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cs(logic v);
    @(negedge clk);
    cs_n = v;
    settle();
  endtask

  task automatic set_sck(logic v);
    @(negedge clk);
    sclk = v;
    settle();
  endtask

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // ending: 0 = CS rise after full word, 1 = extra SCK fall, 2 = abort at bit abort_at
  task automatic run_txn(bit cpol1, int ending, int abort_at);
    logic [DATA_W-1:0] w;
    bit aborted;
    aborted = 1'b0;
    w = DATA_W'($urandom);
    set_cs(1'b1);
    chk("R2 oe released", sdo_oe, 1'b0);
    set_sck(cpol1);
    conv_word = w;
    set_cs(1'b0);
    chk("R3 busy", sdo, 1'b1);
    set_sck(~cpol1);            // clock edges ignored in CONVERT
    set_sck(cpol1);
    chk("R3 sck ignored", sdo, 1'b1);
    wait_until(t0 + CONV / 2);
    chk("R4 still converting", sdo, 1'b1);
    set_cs(1'b1);
    chk("R2 oe off", sdo_oe, 1'b0);
    wait_until(t0 + CONV + 30);
    conv_word = ~w;             // must not reach the word already captured
    set_cs(1'b0);
    chk("R2 oe on", sdo_oe, 1'b1);
    if (cpol1) chk("R6 ready status", sdo, 1'b0);
    else       chk("R7 first bit", sdo, bit_at(w, 0));
    for (int i = 0; i < DATA_W; i++) begin
      if (ending == 2 && i == abort_at) begin
        set_cs(1'b1);
        t0 = cyc;
        chk("R10 oe off on abort", sdo_oe, 1'b0);
        set_cs(1'b0);
        chk("R10 restarted", sdo, 1'b1);
        aborted = 1'b1;
        break;
      end
      if (cpol1) begin
        set_sck(1'b0);
        chk("R6 data bit / R4 capture", sdo, bit_at(w, i));
        set_sck(1'b1);
      end else begin
        chk("R7 data bit / R4 capture", sdo, bit_at(w, i));
        set_sck(1'b1);
        if (i < DATA_W - 1) set_sck(1'b0);
      end
    end
    if (!aborted) begin
      if (ending == 0 || ending == 2) begin
        set_cs(1'b1);
        t0 = cyc;
        chk("R8 oe off", sdo_oe, 1'b0);
        set_cs(1'b0);
        chk("R8 new conversion", sdo, 1'b1);
      end else begin
        set_sck(1'b0);
        t0 = cyc;
        chk("R9 new conversion", sdo, 1'b1);
        chk("R9 oe", sdo_oe, 1'b1);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [DATA_W-1:0] w0;
    void'($urandom(32'd20240611));
    w0 = 16'hA5C3;
    conv_word = w0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 oe in reset", sdo_oe, 1'b0);
    rst = 1'b0;
    t0 = cyc;
    settle();
    chk("R1 oe after reset", sdo_oe, 1'b0);
    chk("R1 sdo after reset", sdo, 1'b0);
    // R11 latency of CS to sdo_oe
    @(negedge clk);
    cs_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 not yet", sdo_oe, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk("R11 fourth edge", sdo_oe, 1'b1);
    chk("R11 busy at fourth edge", sdo, 1'b1);
    settle();
    chk("R1 converting after reset", sdo, 1'b1);
    wait_until(t0 + CONV / 2);
    chk("R4 busy midway", sdo, 1'b1);
    wait_until(t0 + CONV + 30);
    chk("R5 sleep status with cs held low", sdo, 1'b0);
    set_sck(1'b0);
    chk("R6 fall from sleep gives bit 15", sdo, bit_at(w0, 0));
    set_sck(1'b1);
    set_sck(1'b0);
    chk("R6 second bit", sdo, bit_at(w0, 1));
    set_sck(1'b1);
    set_cs(1'b1);
    t0 = cyc;
    chk("R10 abort oe", sdo_oe, 1'b0);
    set_cs(1'b0);
    chk("R10 abort restarts conversion", sdo, 1'b1);

    // fixed corner cases: each ending in each clock polarity
    run_txn(1'b1, 0, 0);
    run_txn(1'b1, 1, 0);
    run_txn(1'b0, 0, 0);
    run_txn(1'b0, 1, 0);
    run_txn(1'b1, 2, 0);
    run_txn(1'b0, 2, 15);
    for (int k = 0; k < 30; k++) begin
      run_txn(1'($urandom % 2), int'($urandom % 3), int'($urandom % DATA_W));
    end
    summary();
  end
endmodule